// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Unit

This block is a sequential multiplier for a small processor pipeline. A one-cycle start pulse launches one operation. The launch cycle captures two 32-bit sources, an operation code and an addend. The addend is either a single 32-bit word or a 64-bit high:low pair. The unit then walks through the multiplier source one byte per cycle, adding one shifted partial product per step into a 64-bit accumulator. When it finishes, it raises a one-cycle done pulse and presents the result as a high word and a low word.

There are six operations: a short multiply, a short multiply-accumulate, and long multiply and long multiply-accumulate, each long form in signed and unsigned variants. The walk stops as soon as the multiplier bits not yet consumed are all zeros. Under signed termination it also stops when those bits are all ones. In that case the last byte is taken as a negative digit, so no extra correction cycle is needed. The total latency is therefore 2 to 5 cycles, depending on the multiplier value.

The controller has two states. In IDLE a start pulse takes the LAUNCH transition into RUN. In RUN the STEP transition stays in RUN while more multiplier bytes remain. The FINISH transition returns to IDLE, writes the result registers and pulses done.

Top module: `iter_mac`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `res_hi` and `res_lo` are 0.
- R2: Op code 0 (short multiply) gives `res_lo` = low 32 bits of `src_a`×`src_b` and `res_hi` = 0. Codes 6 and 7 behave like code 0.
- R3: Op code 1 (short multiply-accumulate) gives `res_lo` = (`src_a`×`src_b` + `add_lo`) mod 2^32 and `res_hi` = 0.
- R4: Op code 2 (unsigned long multiply) gives {`res_hi`,`res_lo`} = the 64-bit product, with both sources taken as unsigned.
- R5: Op code 3 (signed long multiply) gives {`res_hi`,`res_lo`} = the 64-bit two's-complement product of the signed sources.
- R6: Op code 4 (unsigned long multiply-accumulate) gives {`res_hi`,`res_lo`} = (unsigned product + {`add_hi`,`add_lo`}) mod 2^64.
- R7: Op code 5 (signed long multiply-accumulate) gives {`res_hi`,`res_lo`} = (signed product + {`add_hi`,`add_lo`}) mod 2^64.
- R8: Let start be sampled at clock edge E0. Let k be the smallest value in 1..4 for which the bits of `src_b` above bit 8k-1 are all zero, or, for every op except codes 2 and 4, all one. `busy` is high from E0 until edge Ek, and `done` is high between Ek and Ek+1. The total latency is therefore k+1 cycles, from 2 to 5.
- R9: `done` is high for exactly one cycle per operation.
- R10: A start pulse sampled while `busy` is high is ignored. It changes neither the result nor the latency of the operation in flight.
- R11: `res_hi` and `res_lo` hold their values from FINISH until the next FINISH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| op | input | 3 | Operation code (0..5; 6 and 7 act as 0) |
| src_a | input | 32 | Multiplicand |
| src_b | input | 32 | Multiplier; its value sets the latency |
| add_lo | input | 32 | Addend for the short MAC, low accumulator word for long MAC |
| add_hi | input | 32 | High accumulator word for long MAC |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 32 | Result high word (0 for short ops) |
| res_lo | output | 32 | Result low word |

## Verification
All six op codes are swept over every pair drawn from a set of edge values: 0, 1, all ones, the sign bit alone, the largest positive value, 0xFF and 0x100. All ones against the sign bit separates the signed long forms from the unsigned ones. The multipliers 0xFF and 0x100 sit on either side of a byte boundary, so they catch an off-by-one in the early stop. Random operands with random multiplier widths cover every latency from 2 to 5, in both the zero-run and the one-run form. Some runs also drive a second start while the unit is busy, to show that it is ignored.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        OP_MUL32  = 3'd0,
        OP_MAC32  = 3'd1,
        OP_UMUL64 = 3'd2,
        OP_SMUL64 = 3'd3,
        OP_UMAC64 = 3'd4,
        OP_SMAC64 = 3'd5
    } mac_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } mac_state_e;

    typedef struct packed {
        logic sgn;   // signed extension and signed early stop
        logic wide;  // 64-bit result
        logic accum; // add the addend / accumulator
    } op_cfg_t;

    function automatic op_cfg_t decode_op(input logic [2:0] code);
        op_cfg_t c;
        case (code)
            OP_MAC32:  c = '{sgn: 1'b1, wide: 1'b0, accum: 1'b1};
            OP_UMUL64: c = '{sgn: 1'b0, wide: 1'b1, accum: 1'b0};
            OP_SMUL64: c = '{sgn: 1'b1, wide: 1'b1, accum: 1'b0};
            OP_UMAC64: c = '{sgn: 1'b0, wide: 1'b1, accum: 1'b1};
            OP_SMAC64: c = '{sgn: 1'b1, wide: 1'b1, accum: 1'b1};
            default:   c = '{sgn: 1'b1, wide: 1'b0, accum: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mac_term.sv
// Early-stop detector: looks at the multiplier bits not yet consumed.
module mac_term #(
    parameter int XLEN  = 32,
    parameter int DIGIT = 8
) (
    input  logic [XLEN-1:0] mplier,
    input  logic            sgn,
    output logic [XLEN-1:0] rest,
    output logic            last,
    output logic            neg_top
);
    logic rest_zero;
    logic rest_ones;

    always_comb begin
        if (sgn) begin
            rest = XLEN'($signed(mplier) >>> DIGIT);
        end else begin
            rest = mplier >> DIGIT;
        end
        rest_zero = (rest == '0);
        rest_ones = sgn && (rest == '1);
        last      = rest_zero || rest_ones;
        neg_top   = rest_ones;
    end
endmodule

// File: rtl/mac_partial.sv
// One shifted partial product; a trailing all-ones run folds into a negative digit.
module mac_partial #(
    parameter int XLEN  = 32,
    parameter int DIGIT = 8,
    parameter int SW    = 2
) (
    input  logic [2*XLEN-1:0] mcand,
    input  logic [DIGIT-1:0]  digit,
    input  logic              neg_top,
    input  logic [SW-1:0]     step,
    output logic [2*XLEN-1:0] part
);
    localparam int PW  = 2 * XLEN;
    localparam int SHW = $clog2(PW);

    logic [PW-1:0]  digit_ext;
    logic [PW-1:0]  prod;
    logic [SHW-1:0] shamt;

    always_comb begin
        digit_ext = {{(PW-DIGIT){neg_top}}, digit};
        prod      = mcand * digit_ext;
        shamt     = SHW'(step) * SHW'(DIGIT);
        part      = prod << shamt;
    end
endmodule

// File: rtl/iter_mac.sv
module iter_mac
    import mac_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int DIGIT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [XLEN-1:0] add_lo,
    input  logic [XLEN-1:0] add_hi,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] res_hi,
    output logic [XLEN-1:0] res_lo
);
    localparam int PW   = 2 * XLEN;
    localparam int NDIG = XLEN / DIGIT;
    localparam int SW   = (NDIG > 1) ? $clog2(NDIG) : 1;

    mac_state_e state_q, state_d;

    logic [PW-1:0]   acc_q;
    logic [PW-1:0]   mcand_q;
    logic [XLEN-1:0] mplier_q;
    logic            sgn_q;
    logic            wide_q;
    logic [SW-1:0]   step_q;
    logic [XLEN-1:0] res_hi_q, res_lo_q;
    logic            done_q;

    logic [XLEN-1:0] rest;
    logic            fin_last;
    logic            neg_top;
    logic [PW-1:0]   part;
    logic [PW-1:0]   acc_sum;
    op_cfg_t         cfg;

    assign cfg = decode_op(op);

    mac_term #(.XLEN(XLEN), .DIGIT(DIGIT)) u_term (
        .mplier  (mplier_q),
        .sgn     (sgn_q),
        .rest    (rest),
        .last    (fin_last),
        .neg_top (neg_top)
    );

    mac_partial #(.XLEN(XLEN), .DIGIT(DIGIT), .SW(SW)) u_part (
        .mcand   (mcand_q),
        .digit   (mplier_q[DIGIT-1:0]),
        .neg_top (neg_top),
        .step    (step_q),
        .part    (part)
    );

    assign acc_sum = acc_q + part;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state: LAUNCH, STEP, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start)    state_d = S_RUN;   // LAUNCH
            S_RUN:  if (fin_last) state_d = S_IDLE;  // FINISH, else STEP
            default:              state_d = S_IDLE;
        endcase
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            sgn_q    <= 1'b0;
            wide_q   <= 1'b0;
            step_q   <= '0;
            res_hi_q <= '0;
            res_lo_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        mcand_q  <= cfg.sgn ? {{XLEN{src_a[XLEN-1]}}, src_a}
                                            : {{XLEN{1'b0}}, src_a};
                        mplier_q <= src_b;
                        sgn_q    <= cfg.sgn;
                        wide_q   <= cfg.wide;
                        step_q   <= '0;
                        if (!cfg.accum)    acc_q <= '0;
                        else if (cfg.wide) acc_q <= {add_hi, add_lo};
                        else               acc_q <= {{XLEN{1'b0}}, add_lo};
                    end
                end
                S_RUN: begin
                    acc_q    <= acc_sum;
                    mplier_q <= rest;
                    step_q   <= step_q + 1'b1;
                    if (fin_last) begin
                        res_lo_q <= acc_sum[XLEN-1:0];
                        res_hi_q <= wide_q ? acc_sum[PW-1:XLEN] : '0;
                        done_q   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy   = (state_q == S_RUN);
    assign done   = done_q;
    assign res_hi = res_hi_q;
    assign res_lo = res_lo_q;

    // Assertions
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_step_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step_q == SW'(NDIG-1)) |-> fin_last);

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(mcand_q) && $stable(sgn_q) && $stable(wide_q)));

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({res_hi, res_lo}));

endmodule

// File: tb/iter_mac_test.sv
module iter_mac_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] src_a = '0, src_b = '0, add_lo = '0, add_hi = '0;
    logic        busy, done;
    logic [31:0] res_hi, res_lo;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    iter_mac uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .add_lo(add_lo), .add_hi(add_hi),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_lat(input logic [31:0] b, input logic sgn);
        for (int k = 1; k <= 4; k++) begin
            logic [31:0] r;
            r = sgn ? 32'($signed(b) >>> (8*k)) : (b >> (8*k));
            if (r == 32'd0 || (sgn && r == 32'hFFFF_FFFF)) return k + 1;
        end
        return 5;
    endfunction

    function automatic logic [63:0] exp_res(input logic [2:0] o, input logic [31:0] a,
                                            input logic [31:0] b, input logic [31:0] lo,
                                            input logic [31:0] hi);
        logic [63:0] ua, ub, sa, sb;
        ua = {32'd0, a};  ub = {32'd0, b};
        sa = {{32{a[31]}}, a};  sb = {{32{b[31]}}, b};
        case (o)
            3'd1:    return {32'd0, 32'(ua * ub) + lo};  // R3
            3'd2:    return ua * ub;                     // R4
            3'd3:    return sa * sb;                     // R5
            3'd4:    return ua * ub + {hi, lo};          // R6
            3'd5:    return sa * sb + {hi, lo};          // R7
            default: return {32'd0, 32'(ua * ub)};       // R2
        endcase
    endfunction

    function automatic string op_tag(input logic [2:0] o);
        case (o)
            3'd1: return "R3"; 3'd2: return "R4"; 3'd3: return "R5";
            3'd4: return "R6"; 3'd5: return "R7"; default: return "R2";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] lo, input logic [31:0] hi, input bit poke);
        int cnt;
        logic [63:0] e;
        int lat;
        e   = exp_res(o, a, b, lo, hi);
        lat = exp_lat(b, !(o == 3'd2 || o == 3'd4));
        @(negedge clk);
        op = o; src_a = a; src_b = b; add_lo = lo; add_hi = hi; start = 1'b1;
        @(negedge clk);
        cnt = 1;
        chk(busy === 1'b1, "R8 busy after launch", {63'd0, busy}, 64'd1);
        if (poke) begin
            // R10: second start while busy, with different data
            op = 3'd3; src_a = ~a; src_b = 32'h7FFF_FFFF; add_lo = ~lo; add_hi = ~hi;
        end else begin
            start = 1'b0;
        end
        while (!done && cnt < 12) begin
            @(negedge clk);
            cnt++;
            if (cnt == 2) start = 1'b0;
        end
        chk(cnt == lat, poke ? "R10 latency with ignored start" : "R8 latency",
            64'(cnt), 64'(lat));
        chk({res_hi, res_lo} === e, poke ? "R10 result with ignored start" : op_tag(o),
            {res_hi, res_lo}, e);
        @(negedge clk);
        chk(done === 1'b0, "R9 done single cycle", {63'd0, done}, 64'd0);
        chk({res_hi, res_lo} === e, "R11 result held", {res_hi, res_lo}, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_run, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] corner [7];
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
        corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h8000_0000;
        corner[4] = 32'h7FFF_FFFF; corner[5] = 32'h0000_00FF;
        corner[6] = 32'h0000_0100;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && done === 1'b0, "R1 busy/done in reset",
            {62'd0, busy, done}, 64'd0);
        chk({res_hi, res_lo} === 64'd0, "R1 result in reset", {res_hi, res_lo}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 idle after reset",
            {62'd0, busy, done}, 64'd0);

        // Corner sweep over all ops (codes 6 and 7 act as code 0, R2)
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 7; i++)
                for (int j = 0; j < 7; j++)
                    run_op(3'(o), corner[i], corner[j], corner[(i+j) % 7],
                           corner[(i*3+j) % 7], 1'b0);

        // Random operands, random multiplier width for every latency
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a, b;
            int w;
            a = $urandom;
            b = $urandom;
            w = $urandom_range(0, 3);
            if (w < 3) b = $urandom_range(0, 1) ? (b >> (8*(3-w))) : ~(b >> (8*(3-w)));
            run_op(3'($urandom_range(0, 5)), a, b, $urandom, $urandom, (n % 5) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule